// File: doc/BRIEF.md
# Zero-Page Bank Register Port

This block sits next to an 8-bit processor core. It turns core accesses to the two lowest addresses of the 16-bit space into accesses to two small bank registers. Register 0 lives at address 0 and register 1 at address 1. Both are 4 bits wide, and their contents drive the upper address bits that select a memory bank. The choice of which register drives those bits is made elsewhere.

The external bus still runs a cycle whenever the core touches one of these addresses. That cycle is always a read: the pin level for the read/write line stays high and the data drivers stay off. Whatever the external bus returns is dropped, and the core receives the register contents zero-extended to a byte. Writes to a register change only the register.

The two clock phases are modelled as a phase input sampled on one system clock:
- `phi2` low is the first half of a bus cycle.
- `phi2` high is the second half.

The access kind is captured on the clock edge that ends the first half. A register write takes effect on the edge that ends the second half. Reset is synchronous and active high.

Top module: `zpb_port`

## Requirements
- R1: An access is a register access exactly when address bits 15..1 are all zero. Address bit 0 then selects register 0 or register 1. In the strobe vectors `wr_strb` and `rd_strb`, bit i belongs to register i. A register write raises `wr_strb[i]` and a register read raises `rd_strb[i]`.
- R2: While reset is high, and right after it, both registers hold 4'hF (`bank_q` = 8'hFF). At the same time all strobes are 0, `bus_rnw` is 1 and `bus_data_oe` is 0.
- R3: A register write loads `cpu_wdata[3:0]` into the selected register at the end of the second half of the cycle. `cpu_wdata[7:4]` is ignored, and the other register keeps its value. `bank_q[3:0]` is register 0 and `bank_q[7:4]` is register 1.
- R4: During a register access, `bus_rnw` is 1, even when the core writes.
- R5: During a register access, `bus_data_oe` is 0.
- R6: During the second half of a register read, `cpu_rdata` is {4'h0, register}, and `ext_rdata` has no effect.
- R7: Outside register accesses, all strobes are 0 and both registers are unchanged. `bus_rnw` equals the inverse of `cpu_wr` and `bus_data_oe` equals `cpu_wr`.
- R8: During the second half of a non-register access, `cpu_rdata` equals `ext_rdata`. During the first half of any cycle, and throughout a register write, `cpu_rdata` is 8'h00.
- R9: The address and `cpu_wr` are sampled only at the end of the first half. Changes to them during the second half do not alter the strobes, `bus_rnw`, `bus_data_oe` or the register contents for that cycle.
- R10: At most one strobe of the four is active at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| phi2 | input | 1 | Phase: 0 = first half of the bus cycle, 1 = second half |
| cpu_addr | input | 16 | Core address |
| cpu_wr | input | 1 | Core write intent (1 = write) |
| cpu_wdata | input | 8 | Core write data |
| ext_rdata | input | 8 | Data read from the external bus |
| cpu_rdata | output | 8 | Byte delivered to the core |
| bus_rnw | output | 1 | Read/write pin level (1 = read) |
| bus_data_oe | output | 1 | Enable for the external data drivers |
| wr_strb | output | 2 | Register write strobes, bit i = register i |
| rd_strb | output | 2 | Register read strobes, bit i = register i |
| bank_q | output | 8 | Register contents {register 1, register 0} |

## Verification
The following outputs come from the register loaded on the edge that ends the first half, so they are due from that edge onward:
- the strobes,
- `bus_rnw`,
- `bus_data_oe`.

`cpu_rdata` is combinational on that latched state and on `phi2`. It is therefore checked in the first half, where it must be zero, and again in the second half.

A register write lands on the edge that ends the second half. The new value on `bank_q` is therefore checked one clock later, at the falling clock edge that opens the next cycle.

All samples are taken one time unit after a falling clock edge, away from the capturing edge. The split-phase tests change the inputs only after the first-half edge, to confirm that this edge alone decides the access.

// File: rtl/zpb_pkg.sv
package zpb_pkg;

    // Which source feeds the byte returned to the core.
    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_EXT  = 2'd1,
        RD_REG  = 2'd2
    } rd_path_e;

    // Access kind captured at the end of the first half-cycle.
    typedef struct packed {
        logic hit;  // address falls on a bank register
        logic wr;   // core intends to write
    } acc_t;

    function automatic rd_path_e pick_path(logic ph2, acc_t a);
        if (!ph2)
            return RD_NONE;
        else if (a.hit)
            return a.wr ? RD_NONE : RD_REG;
        else
            return RD_EXT;
    endfunction

    // Pin level of the read/write line: a write reaches the bus only off the registers.
    function automatic logic pin_rnw(acc_t a);
        return !(a.wr && !a.hit);
    endfunction

    function automatic logic pin_oe(acc_t a);
        return a.wr && !a.hit;
    endfunction

endpackage

// File: rtl/zpb_decode.sv
module zpb_decode #(
    parameter int ADDR_W = 16,
    parameter int SEL_W  = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [SEL_W-1:0]  idx
);
    // Every address bit above the select field must be zero.
    assign hit = ~|addr[ADDR_W-1:SEL_W];
    assign idx = addr[SEL_W-1:0];
endmodule

// File: rtl/zpb_phase_latch.sv
module zpb_phase_latch
    import zpb_pkg::*;
#(
    parameter int NUM_REGS = 2,
    parameter int SEL_W    = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                phi2,
    input  logic                hit,
    input  logic [SEL_W-1:0]    idx,
    input  logic                wr,
    output acc_t                acc_q,
    output logic [NUM_REGS-1:0] wr_strb,
    output logic [NUM_REGS-1:0] rd_strb,
    output logic                rnw_q,
    output logic                oe_q
);
    acc_t             acc_d;
    logic [SEL_W-1:0] idx_q;

    always_comb begin
        acc_d.hit = hit;
        acc_d.wr  = wr;
    end

    // Closes at the end of the first half; holds through the second half.
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            idx_q <= '0;
            rnw_q <= 1'b1;
            oe_q  <= 1'b0;
        end else if (!phi2) begin
            acc_q <= acc_d;
            idx_q <= idx;
            rnw_q <= pin_rnw(acc_d);
            oe_q  <= pin_oe(acc_d);
        end
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_strb
        logic sel_i;
        assign sel_i      = acc_q.hit && (idx_q == SEL_W'(i));
        assign wr_strb[i] = sel_i && acc_q.wr;
        assign rd_strb[i] = sel_i && !acc_q.wr;
    end
endmodule

// File: rtl/zpb_bank_regs.sv
module zpb_bank_regs #(
    parameter int NUM_REGS = 2,
    parameter int BANK_W   = 4,
    parameter int DATA_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       phi2,
    input  logic [NUM_REGS-1:0]        wr_strb,
    input  logic [DATA_W-1:0]          wdata,
    output logic [NUM_REGS*BANK_W-1:0] bank_q
);
    logic unused_hi;
    assign unused_hi = ^wdata[DATA_W-1:BANK_W];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [BANK_W-1:0] val_q;
        // Loads on the edge that ends the second half-cycle.
        always_ff @(posedge clk) begin
            if (rst)
                val_q <= '1;
            else if (phi2 && wr_strb[i])
                val_q <= wdata[BANK_W-1:0];
        end
        assign bank_q[i*BANK_W +: BANK_W] = val_q;
    end
endmodule

// File: rtl/zpb_read_path.sv
module zpb_read_path
    import zpb_pkg::*;
#(
    parameter int NUM_REGS = 2,
    parameter int BANK_W   = 4,
    parameter int DATA_W   = 8
) (
    input  logic                       phi2,
    input  acc_t                       acc_q,
    input  logic [NUM_REGS-1:0]        rd_strb,
    input  logic [NUM_REGS*BANK_W-1:0] bank_q,
    input  logic [DATA_W-1:0]          ext_rdata,
    output logic [DATA_W-1:0]          cpu_rdata
);
    localparam int PAD_W = DATA_W - BANK_W;

    logic [BANK_W-1:0] reg_sel;

    // One-hot OR mux over the registers.
    always_comb begin
        reg_sel = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_strb[i])
                reg_sel |= bank_q[i*BANK_W +: BANK_W];
    end

    always_comb begin
        unique case (pick_path(phi2, acc_q))
            RD_REG:  cpu_rdata = {{PAD_W{1'b0}}, reg_sel};
            RD_EXT:  cpu_rdata = ext_rdata;
            default: cpu_rdata = '0;
        endcase
    end
endmodule

// File: rtl/zpb_port.sv
module zpb_port
    import zpb_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int BANK_W   = 4,
    parameter int NUM_REGS = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       phi2,
    input  logic [ADDR_W-1:0]          cpu_addr,
    input  logic                       cpu_wr,
    input  logic [DATA_W-1:0]          cpu_wdata,
    input  logic [DATA_W-1:0]          ext_rdata,
    output logic [DATA_W-1:0]          cpu_rdata,
    output logic                       bus_rnw,
    output logic                       bus_data_oe,
    output logic [NUM_REGS-1:0]        wr_strb,
    output logic [NUM_REGS-1:0]        rd_strb,
    output logic [NUM_REGS*BANK_W-1:0] bank_q
);
    localparam int SEL_W = $clog2(NUM_REGS);

    logic             hit;
    logic [SEL_W-1:0] idx;
    acc_t             acc_q;

    zpb_decode #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_dec (
        .addr (cpu_addr),
        .hit  (hit),
        .idx  (idx)
    );

    zpb_phase_latch #(.NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_lat (
        .clk     (clk),
        .rst     (rst),
        .phi2    (phi2),
        .hit     (hit),
        .idx     (idx),
        .wr      (cpu_wr),
        .acc_q   (acc_q),
        .wr_strb (wr_strb),
        .rd_strb (rd_strb),
        .rnw_q   (bus_rnw),
        .oe_q    (bus_data_oe)
    );

    zpb_bank_regs #(.NUM_REGS(NUM_REGS), .BANK_W(BANK_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .phi2    (phi2),
        .wr_strb (wr_strb),
        .wdata   (cpu_wdata),
        .bank_q  (bank_q)
    );

    zpb_read_path #(.NUM_REGS(NUM_REGS), .BANK_W(BANK_W), .DATA_W(DATA_W)) u_rd (
        .phi2      (phi2),
        .acc_q     (acc_q),
        .rd_strb   (rd_strb),
        .bank_q    (bank_q),
        .ext_rdata (ext_rdata),
        .cpu_rdata (cpu_rdata)
    );
endmodule

// File: rtl/zpb_port_chk.sv
module zpb_port_chk #(
    parameter int DATA_W   = 8,
    parameter int BANK_W   = 4,
    parameter int NUM_REGS = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       phi2,
    input logic [DATA_W-1:0]          cpu_rdata,
    input logic                       bus_rnw,
    input logic                       bus_data_oe,
    input logic [NUM_REGS-1:0]        wr_strb,
    input logic [NUM_REGS-1:0]        rd_strb,
    input logic [NUM_REGS*BANK_W-1:0] bank_q
);
    assert_strobe_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_strb, rd_strb}));

    assert_rnw_high_R4: assert property (@(posedge clk) disable iff (rst)
        (|{wr_strb, rd_strb}) |-> bus_rnw);

    assert_oe_off_R5: assert property (@(posedge clk) disable iff (rst)
        (|{wr_strb, rd_strb}) |-> !bus_data_oe);

    assert_read_pad_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (phi2 && |rd_strb) |-> (cpu_rdata[DATA_W-1:BANK_W] == '0));

    assert_bank_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !(phi2 && |wr_strb) |=> $stable(bank_q));

    assert_phase1_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !phi2 |-> (cpu_rdata == '0));

    assert_plain_access_R7: assert property (@(posedge clk) disable iff (rst)
        !(|{wr_strb, rd_strb}) |-> (bus_rnw != bus_data_oe));
endmodule

bind zpb_port zpb_port_chk #(.DATA_W(DATA_W), .BANK_W(BANK_W), .NUM_REGS(NUM_REGS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .phi2        (phi2),
    .cpu_rdata   (cpu_rdata),
    .bus_rnw     (bus_rnw),
    .bus_data_oe (bus_data_oe),
    .wr_strb     (wr_strb),
    .rd_strb     (rd_strb),
    .bank_q      (bank_q)
);

// File: tb/zpb_port_test.sv
module zpb_port_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        phi2 = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  ext_rdata = '0;
    logic [7:0]  cpu_rdata;
    logic        bus_rnw;
    logic        bus_data_oe;
    logic [1:0]  wr_strb;
    logic [1:0]  rd_strb;
    logic [7:0]  bank_q;

    int checks = 0;
    int errors = 0;

    // Values sampled by run_cycle.
    logic [7:0] s_p1_rdata, s_rdata, s_bank;
    logic [1:0] s_wr, s_rd;
    logic       s_rnw, s_oe;

    always #(PERIOD/2) clk = ~clk;

    zpb_port uut (
        .clk(clk), .rst(rst), .phi2(phi2), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .ext_rdata(ext_rdata), .cpu_rdata(cpu_rdata),
        .bus_rnw(bus_rnw), .bus_data_oe(bus_data_oe), .wr_strb(wr_strb),
        .rd_strb(rd_strb), .bank_q(bank_q)
    );

    typedef struct packed {
        logic [15:0] addr;
        logic        wr;
        logic [7:0]  wd;
        logic [7:0]  ext;
        logic [1:0]  e_wr;
        logic [1:0]  e_rd;
        logic        e_rnw;
        logic        e_oe;
        logic [7:0]  e_rdata;
        logic [7:0]  e_bank;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{16'h0000, 1'b0, 8'h00, 8'hAA, 2'b00, 2'b01, 1'b1, 1'b0, 8'h0F, 8'hFF},
        '{16'h0001, 1'b1, 8'h3C, 8'h55, 2'b10, 2'b00, 1'b1, 1'b0, 8'h00, 8'hCF},
        '{16'h0001, 1'b0, 8'h00, 8'h77, 2'b00, 2'b10, 1'b1, 1'b0, 8'h0C, 8'hCF},
        '{16'h0000, 1'b1, 8'hA5, 8'h99, 2'b01, 2'b00, 1'b1, 1'b0, 8'h00, 8'hC5},
        '{16'h0000, 1'b0, 8'h00, 8'hFF, 2'b00, 2'b01, 1'b1, 1'b0, 8'h05, 8'hC5},
        '{16'h0002, 1'b0, 8'h00, 8'h5A, 2'b00, 2'b00, 1'b1, 1'b0, 8'h5A, 8'hC5},
        '{16'h0002, 1'b1, 8'h12, 8'h00, 2'b00, 2'b00, 1'b0, 1'b1, 8'h00, 8'hC5},
        '{16'h8000, 1'b1, 8'h07, 8'h00, 2'b00, 2'b00, 1'b0, 1'b1, 8'h00, 8'hC5},
        '{16'h8001, 1'b0, 8'h00, 8'hC3, 2'b00, 2'b00, 1'b1, 1'b0, 8'hC3, 8'hC5},
        '{16'h0001, 1'b0, 8'h00, 8'h00, 2'b00, 2'b10, 1'b1, 1'b0, 8'h0C, 8'hC5},
        '{16'hFFFF, 1'b0, 8'h00, 8'h81, 2'b00, 2'b00, 1'b1, 1'b0, 8'h81, 8'hC5},
        '{16'h0100, 1'b1, 8'h0F, 8'h00, 2'b00, 2'b00, 1'b0, 1'b1, 8'h00, 8'hC5},
        '{16'h0000, 1'b0, 8'h00, 8'h3E, 2'b00, 2'b01, 1'b1, 1'b0, 8'h05, 8'hC5}
    };

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One bus cycle. Inputs a1/w1 are presented in the first half;
    // a2/w2 replace them once the second half begins.
    task automatic run_cycle(input logic [15:0] a1, input logic w1, input logic [15:0] a2,
                             input logic w2, input logic [7:0] wd, input logic [7:0] ext);
        phi2 = 1'b0; cpu_addr = a1; cpu_wr = w1; cpu_wdata = wd; ext_rdata = ext;
        #1 s_p1_rdata = cpu_rdata;
        @(negedge clk);
        phi2 = 1'b1; cpu_addr = a2; cpu_wr = w2;
        #1;
        s_wr = wr_strb; s_rd = rd_strb; s_rnw = bus_rnw; s_oe = bus_data_oe; s_rdata = cpu_rdata;
        @(negedge clk);
        #1 s_bank = bank_q;
    endtask

    initial begin
        #(PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state while reset is held
        check("R2", "bank in reset", 32'(bank_q), 32'hFF);
        check("R2", "strobes in reset", 32'({wr_strb, rd_strb}), 32'h0);
        check("R2", "rnw in reset", 32'(bus_rnw), 32'h1);
        check("R2", "oe in reset", 32'(bus_data_oe), 32'h0);
        rst = 1'b0;
        @(negedge clk);

        // Table walk: R1 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            run_cycle(VECS[i].addr, VECS[i].wr, VECS[i].addr, VECS[i].wr, VECS[i].wd, VECS[i].ext);
            check("R1", $sformatf("v%0d wr_strb", i), 32'(s_wr), 32'(VECS[i].e_wr));
            check("R1", $sformatf("v%0d rd_strb", i), 32'(s_rd), 32'(VECS[i].e_rd));
            check("R4/R7", $sformatf("v%0d rnw", i), 32'(s_rnw), 32'(VECS[i].e_rnw));
            check("R5/R7", $sformatf("v%0d oe", i), 32'(s_oe), 32'(VECS[i].e_oe));
            check("R6/R8", $sformatf("v%0d rdata", i), 32'(s_rdata), 32'(VECS[i].e_rdata));
            check("R8", $sformatf("v%0d phase1 rdata", i), 32'(s_p1_rdata), 32'h0);
            check("R3", $sformatf("v%0d bank", i), 32'(s_bank), 32'(VECS[i].e_bank));
        end

        // R9: a read sampled in the first half stays a read despite a write request later
        run_cycle(16'h0000, 1'b0, 16'h1234, 1'b1, 8'h0A, 8'h66);
        check("R9", "split rd_strb", 32'(s_rd), 32'h1);
        check("R9", "split wr_strb", 32'(s_wr), 32'h0);
        check("R9", "split rnw", 32'(s_rnw), 32'h1);
        check("R9", "split rdata", 32'(s_rdata), 32'h05);
        check("R9", "split bank", 32'(s_bank), 32'hC5);

        // R9: a plain read cannot become a register write in the second half
        run_cycle(16'h4000, 1'b0, 16'h0001, 1'b1, 8'h09, 8'h24);
        check("R9", "late write strobes", 32'({s_wr, s_rd}), 32'h0);
        check("R9", "late write bank", 32'(s_bank), 32'hC5);
        check("R9", "late write rdata", 32'(s_rdata), 32'h24);

        // R3: upper data bits ignored, register 1 only changes
        run_cycle(16'h0001, 1'b1, 16'h0001, 1'b1, 8'hF0, 8'hFF);
        check("R3", "upper bits ignored", 32'(s_bank), 32'h05);

        // R2: reset mid-run restores all ones
        rst = 1'b1;
        repeat (2) @(negedge clk);
        #1 check("R2", "bank after late reset", 32'(bank_q), 32'hFF);
        check("R2", "rnw after late reset", 32'(bus_rnw), 32'h1);
        rst = 1'b0;
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule